// File: doc/BRIEF.md
# Multirate Token Arc Controller

This block governs one edge of a synchronous dataflow graph: a queue of tokens between a producer actor and a consumer actor. Every producer firing pushes a fixed batch of tokens, and every consumer firing pulls a fixed batch. Each actor fires only when the token count allows it. The queue can start with a set number of delay tokens, loaded during reset. The consumer only dequeues; it performs no arithmetic on the tokens.

The block reports which actor may fire and which one fires. It also gives the current occupancy and keeps a shift register of the recent firing order. From the default rates it derives the balanced repetition counts: two producer firings and three consumer firings per period. It pulses a flag when a period completes. A sticky error flag records a period boundary where the occupancy disagrees with the balance equations.

Top module: `arc_dataflow_ctrl`

## Requirements
- R1: After reset, occupancy equals DELAY_TOKENS. period_done, rate_err and fire_trace are all zero.
- R2: prod_en is high exactly when the free space (DEPTH minus occupancy) is at least PROD_RATE (default 3). The producer never fires while prod_en is low.
- R3: cons_en is high exactly when occupancy is at least CONS_RATE (default 2). A consumer firing presents CONS_RATE tokens on cons_tokens in the same cycle.
- R4: Tokens leave the queue in the order they entered. Token k of prod_tokens, at bits [k*DATA_W +: DATA_W], enters before token k+1. On cons_tokens, token 0 in the low bits is the oldest.
- R5: The DELAY_TOKENS preloaded tokens hold the values 0, 1, 2 and so on, oldest first.
- R6: When both actors request and both are enabled, only the consumer fires. With zero delay tokens and both requests held high, the firing order is producer, consumer, producer, consumer, consumer.
- R7: On the clock edge of a firing, occupancy rises by PROD_RATE after a producer firing and falls by CONS_RATE after a consumer firing. It is visible the following cycle.
- R8: period_done is high for exactly one cycle. It follows the firing that brings the counts to at least 2 producer firings and 3 consumer firings. Those counts are then reduced by 2 and 3.
- R9: rate_err is sticky. It is set when the occupancy at a period boundary differs from DELAY_TOKENS plus the occupancy of the surplus firings. With consistent rates it stays low.
- R10: fire_trace shifts left by one on every firing. A 1 enters for a producer firing and a 0 for a consumer firing.
- R11: An actor whose request is low does not fire. In a cycle without a firing, occupancy is unchanged.
- R12: The dequeued token stream is identical for the orders producer-producer-consumer-consumer-consumer and producer-consumer-producer-consumer-consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_req | input | 1 | Producer asks to fire |
| prod_tokens | input | PROD_RATE*DATA_W | Batch enqueued by a producer firing |
| cons_req | input | 1 | Consumer asks to fire |
| prod_en | output | 1 | Room exists for a full producer batch |
| cons_en | output | 1 | Enough tokens exist for a consumer firing |
| prod_fire | output | 1 | Producer fires this cycle |
| cons_fire | output | 1 | Consumer fires this cycle |
| cons_tokens | output | CONS_RATE*DATA_W | Tokens dequeued by the consumer firing |
| occupancy | output | $clog2(DEPTH+1) | Tokens currently on the arc |
| period_done | output | 1 | One-cycle pulse at a completed period |
| rate_err | output | 1 | Sticky balance mismatch flag |
| fire_trace | output | TRACE_LEN | Recent firing history, newest in bit 0 |

## Verification
The bench builds two instances, each with rates 3 and 2 and a depth of 8. The first starts empty. With it, consumer-first arbitration, the producer stall at occupancy 6, both period orderings and the stream comparison between them can all be reached. The second preloads four delay tokens. It exposes the preload values and lets the consumer fire straight after reset, with no producer firing. A depth of 8 means the producer stalls after two batches, which exercises the free-space rule.

// File: rtl/arc_pkg.sv
package arc_pkg;

    typedef struct packed {
        logic prod;
        logic cons;
    } fire_t;

    function automatic int gcd_int(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int reps_of_prod(input int prate, input int crate);
        return crate / gcd_int(prate, crate);
    endfunction

    function automatic int reps_of_cons(input int prate, input int crate);
        return prate / gcd_int(prate, crate);
    endfunction

endpackage

// File: rtl/arc_token_fifo.sv
module arc_token_fifo #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 8,
    parameter int PUSH_N  = 3,
    parameter int POP_N   = 2,
    parameter int PRELOAD = 0,
    parameter int CW      = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [PUSH_N*DATA_W-1:0] push_data,
    input  logic                     pop,
    output logic [POP_N*DATA_W-1:0]  pop_data,
    output logic [CW-1:0]            count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    function automatic logic [PW-1:0] wrap(input logic [PW-1:0] base, input int k);
        int s;
        s = int'(base) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    genvar g;
    generate
        for (g = 0; g < POP_N; g++) begin : g_rd
            assign pop_data[g*DATA_W +: DATA_W] = mem[wrap(rd_ptr, g)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < PRELOAD) ? DATA_W'(i) : '0;
            end
            wr_ptr <= PW'(PRELOAD % DEPTH);
            rd_ptr <= '0;
            count  <= CW'(PRELOAD);
        end else begin
            if (push) begin
                for (int k = 0; k < PUSH_N; k++) begin
                    mem[wrap(wr_ptr, k)] <= push_data[k*DATA_W +: DATA_W];
                end
                wr_ptr <= wrap(wr_ptr, PUSH_N % DEPTH);
            end
            if (pop) begin
                rd_ptr <= wrap(rd_ptr, POP_N % DEPTH);
            end
            count <= CW'(int'(count) + (push ? PUSH_N : 0) - (pop ? POP_N : 0));
        end
    end
endmodule

// File: rtl/arc_fire_ctrl.sv
module arc_fire_ctrl
    import arc_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int PROD_RATE = 3,
    parameter int CONS_RATE = 2,
    parameter int CW        = 4
) (
    input  logic          prod_req,
    input  logic          cons_req,
    input  logic [CW-1:0] count,
    output logic          prod_en,
    output logic          cons_en,
    output fire_t         fire
);
    always_comb begin
        prod_en   = (DEPTH - int'(count)) >= PROD_RATE;
        cons_en   = int'(count) >= CONS_RATE;
        fire.cons = cons_req && cons_en;
        fire.prod = prod_req && prod_en && !fire.cons;
    end
endmodule

// File: rtl/arc_period_mon.sv
module arc_period_mon
    import arc_pkg::*;
#(
    parameter int PROD_RATE = 3,
    parameter int CONS_RATE = 2,
    parameter int DELAY     = 0,
    parameter int CW        = 4,
    parameter int TRACE_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fire_t                fire,
    input  logic [CW-1:0]        count,
    output logic                 period_done,
    output logic                 rate_err,
    output logic [TRACE_LEN-1:0] trace
);
    localparam int REP_P = reps_of_prod(PROD_RATE, CONS_RATE);
    localparam int REP_C = reps_of_cons(PROD_RATE, CONS_RATE);

    logic [7:0] p_cnt;
    logic [7:0] c_cnt;
    int         p_nxt;
    int         c_nxt;
    int         occ_nxt;
    int         occ_want;
    logic       complete;

    always_comb begin
        p_nxt    = int'(p_cnt) + (fire.prod ? 1 : 0);
        c_nxt    = int'(c_cnt) + (fire.cons ? 1 : 0);
        occ_nxt  = int'(count) + (fire.prod ? PROD_RATE : 0) - (fire.cons ? CONS_RATE : 0);
        complete = (p_nxt >= REP_P) && (c_nxt >= REP_C);
        occ_want = DELAY + PROD_RATE * (p_nxt - REP_P) - CONS_RATE * (c_nxt - REP_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_cnt       <= '0;
            c_cnt       <= '0;
            period_done <= 1'b0;
            rate_err    <= 1'b0;
            trace       <= '0;
        end else begin
            period_done <= complete;
            if (complete) begin
                p_cnt <= 8'(p_nxt - REP_P);
                c_cnt <= 8'(c_nxt - REP_C);
                if (occ_nxt != occ_want) rate_err <= 1'b1;
            end else begin
                p_cnt <= 8'(p_nxt);
                c_cnt <= 8'(c_nxt);
            end
            if (fire.prod || fire.cons) begin
                trace <= {trace[TRACE_LEN-2:0], fire.prod};
            end
        end
    end
endmodule

// File: rtl/arc_dataflow_ctrl.sv
module arc_dataflow_ctrl
    import arc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PROD_RATE    = 3,
    parameter int CONS_RATE    = 2,
    parameter int DELAY_TOKENS = 0,
    parameter int DEPTH        = 8,
    parameter int TRACE_LEN    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prod_req,
    input  logic [PROD_RATE*DATA_W-1:0] prod_tokens,
    input  logic                        cons_req,
    output logic                        prod_en,
    output logic                        cons_en,
    output logic                        prod_fire,
    output logic                        cons_fire,
    output logic [CONS_RATE*DATA_W-1:0] cons_tokens,
    output logic [$clog2(DEPTH+1)-1:0]  occupancy,
    output logic                        period_done,
    output logic                        rate_err,
    output logic [TRACE_LEN-1:0]        fire_trace
);
    localparam int CW = $clog2(DEPTH + 1);

    fire_t         fire;
    logic [CW-1:0] count;

    arc_fire_ctrl #(
        .DEPTH(DEPTH), .PROD_RATE(PROD_RATE), .CONS_RATE(CONS_RATE), .CW(CW)
    ) u_ctrl (
        .prod_req(prod_req), .cons_req(cons_req), .count(count),
        .prod_en(prod_en), .cons_en(cons_en), .fire(fire)
    );

    arc_token_fifo #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .PUSH_N(PROD_RATE), .POP_N(CONS_RATE),
        .PRELOAD(DELAY_TOKENS), .CW(CW)
    ) u_fifo (
        .clk(clk), .rst(rst), .push(fire.prod), .push_data(prod_tokens),
        .pop(fire.cons), .pop_data(cons_tokens), .count(count)
    );

    arc_period_mon #(
        .PROD_RATE(PROD_RATE), .CONS_RATE(CONS_RATE), .DELAY(DELAY_TOKENS),
        .CW(CW), .TRACE_LEN(TRACE_LEN)
    ) u_mon (
        .clk(clk), .rst(rst), .fire(fire), .count(count),
        .period_done(period_done), .rate_err(rate_err), .trace(fire_trace)
    );

    assign prod_fire = fire.prod;
    assign cons_fire = fire.cons;
    assign occupancy = count;
endmodule

// File: rtl/arc_dataflow_ctrl_chk.sv
module arc_dataflow_ctrl_chk #(
    parameter int DEPTH     = 8,
    parameter int PROD_RATE = 3,
    parameter int CONS_RATE = 2,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          prod_req,
    input logic          cons_req,
    input logic          prod_fire,
    input logic          cons_fire,
    input logic [CW-1:0] occupancy,
    input logic          period_done,
    input logic          rate_err
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        int'(occupancy) <= DEPTH);

    assert_prod_room_R2: assert property (@(posedge clk) disable iff (rst)
        prod_fire |-> (DEPTH - int'(occupancy)) >= PROD_RATE);

    assert_cons_tokens_R3: assert property (@(posedge clk) disable iff (rst)
        cons_fire |-> int'(occupancy) >= CONS_RATE);

    assert_cons_priority_R6: assert property (@(posedge clk) disable iff (rst)
        cons_fire |-> !prod_fire);

    assert_occ_step_R7: assert property (@(posedge clk) disable iff (rst)
        (prod_fire || cons_fire) |=> int'(occupancy) ==
            int'($past(occupancy)) + ($past(prod_fire) ? PROD_RATE : 0)
                                   - ($past(cons_fire) ? CONS_RATE : 0));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        period_done |=> !period_done);

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
        rate_err |=> rate_err);

    assert_idle_prod_R11: assert property (@(posedge clk) disable iff (rst)
        !prod_req |-> !prod_fire);

    assert_idle_cons_R11: assert property (@(posedge clk) disable iff (rst)
        !cons_req |-> !cons_fire);

    assert_occ_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!prod_fire && !cons_fire) |=> $stable(occupancy));
endmodule

bind arc_dataflow_ctrl arc_dataflow_ctrl_chk #(
    .DEPTH(DEPTH), .PROD_RATE(PROD_RATE), .CONS_RATE(CONS_RATE), .CW($clog2(DEPTH + 1))
) u_chk (
    .clk(clk), .rst(rst), .prod_req(prod_req), .cons_req(cons_req),
    .prod_fire(prod_fire), .cons_fire(cons_fire), .occupancy(occupancy),
    .period_done(period_done), .rate_err(rate_err)
);

// File: tb/arc_dataflow_ctrl_tb.sv
`timescale 1ns/1ps
module arc_dataflow_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        prod_req = 1'b0, cons_req = 1'b0;
    logic [23:0] prod_tokens = '0;
    logic        prod_en, cons_en, prod_fire, cons_fire, period_done, rate_err;
    logic [15:0] cons_tokens;
    logic [3:0]  occupancy;
    logic [7:0]  fire_trace;

    logic        d_cons_req = 1'b0;
    logic        d_prod_en, d_cons_en, d_prod_fire, d_cons_fire, d_pd, d_err;
    logic [15:0] d_tokens;
    logic [3:0]  d_occ;
    logic [7:0]  d_trace;

    arc_dataflow_ctrl #(.DELAY_TOKENS(0), .DEPTH(8)) u_dut (
        .clk(clk), .rst(rst), .prod_req(prod_req), .prod_tokens(prod_tokens),
        .cons_req(cons_req), .prod_en(prod_en), .cons_en(cons_en),
        .prod_fire(prod_fire), .cons_fire(cons_fire), .cons_tokens(cons_tokens),
        .occupancy(occupancy), .period_done(period_done), .rate_err(rate_err),
        .fire_trace(fire_trace));

    arc_dataflow_ctrl #(.DELAY_TOKENS(4), .DEPTH(8)) u_dut_dly (
        .clk(clk), .rst(rst), .prod_req(1'b0), .prod_tokens(24'd0),
        .cons_req(d_cons_req), .prod_en(d_prod_en), .cons_en(d_cons_en),
        .prod_fire(d_prod_fire), .cons_fire(d_cons_fire), .cons_tokens(d_tokens),
        .occupancy(d_occ), .period_done(d_pd), .rate_err(d_err),
        .fire_trace(d_trace));

    int errors = 0, checks = 0;
    int occ_m = 0, pc = 0, cc = 0, nv = 16;
    logic [7:0] trace_m = '0;
    int exp_q[$];
    int rec[$];
    bit finished = 0;

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // One firing opportunity on u_dut; called and returns at a falling edge.
    task automatic step(input logic pr, input logic cr);
        logic epe, ece, epf, ecf, epd;
        int a, b;
        prod_req = pr;
        cons_req = cr;
        prod_tokens = {8'(nv + 2), 8'(nv + 1), 8'(nv)};
        #1;
        epe = (8 - occ_m) >= 3;
        ece = occ_m >= 2;
        ecf = cr && ece;
        epf = pr && epe && !ecf;
        chk(prod_en == epe, "R2 prod_en", prod_en, epe);
        chk(cons_en == ece, "R3 cons_en", cons_en, ece);
        chk(cons_fire == ecf, "R6/R11 cons_fire", cons_fire, ecf);
        chk(prod_fire == epf, "R6/R11 prod_fire", prod_fire, epf);
        if (ecf) begin
            a = exp_q.pop_front();
            b = exp_q.pop_front();
            chk(cons_tokens[7:0] == 8'(a), "R4 oldest token", cons_tokens[7:0], a);
            chk(cons_tokens[15:8] == 8'(b), "R4 second token", cons_tokens[15:8], b);
            rec.push_back(int'(cons_tokens[7:0]));
            rec.push_back(int'(cons_tokens[15:8]));
            occ_m -= 2; cc++;
            trace_m = {trace_m[6:0], 1'b0};
        end
        if (epf) begin
            exp_q.push_back(nv & 255); exp_q.push_back((nv + 1) & 255); exp_q.push_back((nv + 2) & 255);
            nv += 3; occ_m += 3; pc++;
            trace_m = {trace_m[6:0], 1'b1};
        end
        epd = (pc >= 2) && (cc >= 3);
        if (epd) begin pc -= 2; cc -= 3; end
        @(posedge clk);
        @(negedge clk);
        chk(occupancy == 4'(occ_m), "R7 occupancy", occupancy, occ_m);
        chk(period_done == epd, "R8 period_done", period_done, epd);
        chk(fire_trace == trace_m, "R10 fire_trace", fire_trace, trace_m);
        prod_req = 1'b0;
        cons_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(occupancy == 4'd0, "R1 occupancy", occupancy, 0);
        chk(period_done == 1'b0, "R1 period_done", period_done, 0);
        chk(rate_err == 1'b0, "R1 rate_err", rate_err, 0);
        chk(fire_trace == 8'd0, "R1 fire_trace", fire_trace, 0);
        chk(d_occ == 4'd4, "R1 delay occupancy", d_occ, 4);
        #1;
        chk(prod_en == 1'b1 && cons_en == 1'b0, "R3 empty enables", {prod_en, cons_en}, 2);
    endtask

    // R6: both requesting from empty gives A B A B B.
    task automatic t_consumer_first();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        chk(fire_trace[4:0] == 5'b10100, "R6 order ABABB", fire_trace[4:0], 5'b10100);
        chk(occupancy == 4'd0, "R8 period returns to start", occupancy, 0);
    endtask

    // R2/R11: producer stalls at occupancy 6, then drain.
    task automatic t_stall();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk(occupancy == 4'd6, "R2 stalled occupancy", occupancy, 6);
        step(1'b0, 1'b0);
        chk(occupancy == 4'd6, "R11 idle holds", occupancy, 6);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(occupancy == 4'd0, "R3 no consume when empty", occupancy, 0);
    endtask

    // R12: compare streams of the two valid orderings.
    task automatic t_orders();
        int s1[$];
        rec.delete();
        nv = 100;
        step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1);
        s1 = rec;
        rec.delete();
        nv = 100;
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
        chk(s1.size() == 6 && rec.size() == 6, "R12 stream length", rec.size(), 6);
        for (int i = 0; i < 6; i++) begin
            chk(s1[i] == rec[i], "R12 stream match", rec[i], s1[i]);
        end
        chk(fire_trace[4:0] == 5'b11000, "R10 order AABBB", fire_trace[4:0], 5'b11000);
    endtask

    // R5: preloaded delay tokens on the second instance.
    task automatic t_delay();
        d_cons_req = 1'b1;
        #1;
        chk(d_cons_fire == 1'b1, "R5 fire on delay tokens", d_cons_fire, 1);
        chk(d_tokens == 16'h0100, "R5 first delay pair", d_tokens, 16'h0100);
        @(posedge clk); @(negedge clk);
        #1;
        chk(d_tokens == 16'h0302, "R5 second delay pair", d_tokens, 16'h0302);
        @(posedge clk); @(negedge clk);
        #1;
        chk(d_occ == 4'd0 && d_cons_en == 1'b0, "R3 delay drained", d_occ, 0);
        d_cons_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_consumer_first();
        t_stall();
        t_orders();
        t_delay();
        chk(rate_err == 1'b0 && d_err == 1'b0, "R9 rate_err low", rate_err, 0);
        finish_run();
    end
endmodule